// File: doc/BRIEF.md
# Multi-Level IO Translation Cache

This block holds a small, fully associative set of recently used IO page-table leaf entries. Each entry serves one requester, identified by a 16-bit source ID, and one page of 4 KiB (level 1), 2 MiB (level 2) or 1 GiB (level 3). Pages of all three sizes share the same storage. A lookup presents a source ID and an address. The block probes the tag for each of the three levels and answers with the translated base, the offset mask, the permission code and the level. On a miss the walker outside the block resolves the translation and writes it back through the fill port.

Invalidation requests remove entries in one of three ways. A global request clears everything. A domain request removes the entries tagged with one domain ID. A page request removes a power-of-two range of 4 KiB frames within a domain, and it also removes any large entry that contains the flushed address. Each invalidation completes in one cycle and is acknowledged by a done pulse.

Top module: `io_xlate_cache`

## Requirements
- R1: After reset the cache is empty, every lookup misses, and rspValid, rspHit, rspAddr, rspOffsetMask, rspPerm, rspLevel and invDone are all 0.
- R2: A lookup gives its result on the clock edge after the cycle in which lookupValid is high, and rspValid is high for that one cycle. The lookup sees the contents as they stood before any fill or invalidation in the same cycle. On a miss, rspHit, rspAddr, rspOffsetMask, rspPerm and rspLevel are 0.
- R3: An entry's tag is made of its source ID, its level and its frame. The frame is address bits [47:12] with every bit below the level shift cleared, where the shift is 12 + 9*(level-1). An entry hits for any address in its page, and only when the source ID is the same.
- R4: When tags at more than one level match, level 1 wins over level 2, and level 2 wins over level 3.
- R5: On a hit, the outputs are formed as follows. rspAddr is the stored leaf with the bits below the level shift cleared, and rspOffsetMask is the complement of that page mask. rspPerm is {write, read}, with bit 1 for write and bit 0 for read. rspLevel is 1, 2 or 3.
- R6: A fill whose tag (source ID, level, frame) is already present overwrites that entry in place. No second entry is created, so no capacity is used.
- R7: A fill with a new tag, arriving when all NUM_ENTRIES entries are valid, first empties the cache and then stores only the new entry.
- R8: An invalidation with invKind 0 (global) removes every entry. For every invValid, whatever its kind, invDone is high exactly on the following cycle.
- R9: An invalidation with invKind 1 (domain) removes exactly the entries whose domain ID equals invDid.
- R10: An invalidation with invKind 2 (page) and order am removes an entry when its domain equals invDid and either of two conditions holds. The first is that the entry frame with its low am bits cleared equals invAddr[47:12] with its low am bits cleared. The second is that the entry frame equals invAddr masked by the entry's own page mask.
- R11: invKind 3 removes nothing. A fill in the same cycle as invValid is dropped. A fill with fillLevel 0 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupValid | input | 1 | Lookup request |
| lookupSid | input | 16 | Source ID of the lookup |
| lookupAddr | input | 48 | Address to translate |
| fillValid | input | 1 | Insert request |
| fillSid | input | 16 | Source ID of the new entry |
| fillDid | input | 16 | Domain ID of the new entry |
| fillAddr | input | 48 | Address covered by the new entry |
| fillLeaf | input | 48 | Leaf value (output base) |
| fillRead | input | 1 | Read permission |
| fillWrite | input | 1 | Write permission |
| fillLevel | input | 2 | Page level 1..3; 0 drops the fill |
| invValid | input | 1 | Invalidation request |
| invKind | input | 2 | 0 global, 1 domain, 2 page, 3 none |
| invDid | input | 16 | Domain for domain/page kinds |
| invAddr | input | 48 | Address for page kind |
| invOrder | input | 6 | Address-mask order for page kind |
| rspValid | output | 1 | Lookup result valid |
| rspHit | output | 1 | Lookup hit |
| rspAddr | output | 48 | Translated page base |
| rspOffsetMask | output | 48 | Mask of the in-page offset bits |
| rspPerm | output | 2 | {write, read} |
| rspLevel | output | 2 | Level of the hit entry |
| invDone | output | 1 | Invalidation completed |

## Verification
Every result of this block is due exactly one edge after its request. A lookup result appears on the rsp outputs one cycle later. A fill or an invalidation changes what the next lookup can return. invDone follows invValid by one cycle. The bench keeps a behavioural model built on a queue. At each rising edge the model computes the one-cycle-delayed response from its state before the update, and only then applies any fill or invalidation. The outputs are compared on the falling edge, so each field is checked in the very cycle it is due. Directed checks also compare hand-computed values at the hit corners, large-page masks, level priority, overflow, both kinds of page-invalidation match, and the dropped requests.

// File: rtl/ioxc_pkg.sv
package ioxc_pkg;

  localparam int PAGE_SHIFT = 12;
  localparam int LEVEL_BITS = 9;

  typedef enum logic [1:0] {
    INV_GLOBAL = 2'd0,
    INV_DOMAIN = 2'd1,
    INV_PAGE   = 2'd2,
    INV_NONE   = 2'd3
  } invKind_e;

  typedef struct packed {
    logic     invEn;
    invKind_e invKind;
    logic     fillEn;
    logic     flushAll;
  } ctrlStrb_t;

  function automatic int levelShift(input logic [1:0] lvl);
    return PAGE_SHIFT + (int'(lvl) - 1) * LEVEL_BITS;
  endfunction

endpackage

// File: rtl/ioxc_ctrl.sv
module ioxc_ctrl
  import ioxc_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int SLOT_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   fillValid,
  input  logic [1:0]             fillLevel,
  input  logic                   invValid,
  input  logic [1:0]             invKind,
  input  logic [NUM_ENTRIES-1:0] validVec,
  input  logic [NUM_ENTRIES-1:0] fillMatchVec,
  output ctrlStrb_t              strb,
  output logic [SLOT_W-1:0]      fillSlot,
  output logic                   invDone
);

  logic [SLOT_W-1:0] matchIdx;
  logic [SLOT_W-1:0] freeIdx;

  always_comb begin
    matchIdx = '0;
    freeIdx  = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (fillMatchVec[i]) matchIdx = SLOT_W'(i);
      if (!validVec[i])    freeIdx  = SLOT_W'(i);
    end
  end

  always_comb begin
    strb     = '0;
    fillSlot = '0;
    if (invValid) begin
      strb.invEn   = 1'b1;
      strb.invKind = invKind_e'(invKind);
    end else if (fillValid && fillLevel != 2'd0) begin
      strb.fillEn = 1'b1;
      if (|fillMatchVec) begin
        fillSlot = matchIdx;
      end else if (!(&validVec)) begin
        fillSlot = freeIdx;
      end else begin
        strb.flushAll = 1'b1;
        fillSlot      = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) invDone <= 1'b0;
    else       invDone <= invValid;
  end

  // R6: a new tag never lands on an occupied slot unless the cache is flushed
  p_alloc_free_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fillEn && !strb.flushAll && !(|fillMatchVec)) |-> !validVec[fillSlot]);

endmodule

// File: rtl/ioxc_store.sv
module ioxc_store
  import ioxc_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 48,
  parameter int SID_W       = 16,
  parameter int DID_W       = 16,
  parameter int ORDER_W     = 6,
  parameter int SLOT_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrb_t              strb,
  input  logic [SLOT_W-1:0]      fillSlot,
  input  logic [SID_W-1:0]       fillSid,
  input  logic [DID_W-1:0]       fillDid,
  input  logic [ADDR_W-1:0]      fillAddr,
  input  logic [ADDR_W-1:0]      fillLeaf,
  input  logic                   fillRead,
  input  logic                   fillWrite,
  input  logic [1:0]             fillLevel,
  input  logic [DID_W-1:0]       invDid,
  input  logic [ADDR_W-1:0]      invAddr,
  input  logic [ORDER_W-1:0]     invOrder,
  input  logic                   lookupValid,
  input  logic [SID_W-1:0]       lookupSid,
  input  logic [ADDR_W-1:0]      lookupAddr,
  output logic [NUM_ENTRIES-1:0] validVec,
  output logic [NUM_ENTRIES-1:0] fillMatchVec,
  output logic                   rspValid,
  output logic                   rspHit,
  output logic [ADDR_W-1:0]      rspAddr,
  output logic [ADDR_W-1:0]      rspOffsetMask,
  output logic [1:0]             rspPerm,
  output logic [1:0]             rspLevel
);

  localparam int FRAME_W = ADDR_W - PAGE_SHIFT;

  function automatic logic [ADDR_W-1:0] lvlMask(input logic [1:0] lvl);
    return {ADDR_W{1'b1}} << levelShift(lvl);
  endfunction

  logic [NUM_ENTRIES-1:0] entValid;
  logic [SID_W-1:0]       entSid   [NUM_ENTRIES];
  logic [DID_W-1:0]       entDid   [NUM_ENTRIES];
  logic [FRAME_W-1:0]     entFrame [NUM_ENTRIES];
  logic [ADDR_W-1:0]      entLeaf  [NUM_ENTRIES];
  logic [1:0]             entLevel [NUM_ENTRIES];
  logic                   entRd    [NUM_ENTRIES];
  logic                   entWr    [NUM_ENTRIES];

  assign validVec = entValid;

  // lookup probes, one per cached level
  logic [3:1][NUM_ENTRIES-1:0] hitVec;
  logic [3:1][FRAME_W-1:0]     probeFrame;

  for (genvar lv = 1; lv <= 3; lv++) begin : g_probe
    localparam logic [1:0] LV = 2'(lv);
    logic [ADDR_W-1:0] probeMask;
    assign probeMask      = lvlMask(LV);
    assign probeFrame[lv] = lookupAddr[ADDR_W-1:PAGE_SHIFT] & probeMask[ADDR_W-1:PAGE_SHIFT];
    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
      assign hitVec[lv][i] = entValid[i] && entSid[i] == lookupSid &&
                             entLevel[i] == LV && entFrame[i] == probeFrame[lv];
    end
  end

  logic              found;
  logic [SLOT_W-1:0] selIdx;

  always_comb begin
    found  = 1'b0;
    selIdx = '0;
    for (int lv = 1; lv <= 3; lv++) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (!found && hitVec[lv][i]) begin
          found  = 1'b1;
          selIdx = SLOT_W'(i);
        end
      end
    end
  end

  // fill tag and invalidation matching
  logic [ADDR_W-1:0]      fillMask;
  logic [FRAME_W-1:0]     fillFrame;
  logic [FRAME_W-1:0]     invOrderMask;
  logic [FRAME_W-1:0]     invFrame;
  logic [NUM_ENTRIES-1:0] killVec;
  logic [NUM_ENTRIES-1:0] slotHot;

  assign fillMask     = lvlMask(fillLevel);
  assign fillFrame    = fillAddr[ADDR_W-1:PAGE_SHIFT] & fillMask[ADDR_W-1:PAGE_SHIFT];
  assign invOrderMask = {FRAME_W{1'b1}} << invOrder;
  assign invFrame     = invAddr[ADDR_W-1:PAGE_SHIFT] & invOrderMask;
  assign slotHot      = {{(NUM_ENTRIES-1){1'b0}}, 1'b1} << fillSlot;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_match
    logic [ADDR_W-1:0]  entMask;
    logic [FRAME_W-1:0] tlbFrame;
    logic               didHit;
    logic               pageHit;
    assign entMask  = lvlMask(entLevel[i]);
    assign tlbFrame = invAddr[ADDR_W-1:PAGE_SHIFT] & entMask[ADDR_W-1:PAGE_SHIFT];
    assign didHit   = entDid[i] == invDid;
    assign pageHit  = didHit && (((entFrame[i] & invOrderMask) == invFrame) ||
                                 (entFrame[i] == tlbFrame));
    always_comb begin
      unique case (strb.invKind)
        INV_GLOBAL: killVec[i] = 1'b1;
        INV_DOMAIN: killVec[i] = didHit;
        INV_PAGE:   killVec[i] = pageHit;
        default:    killVec[i] = 1'b0;
      endcase
    end
    assign fillMatchVec[i] = entValid[i] && entSid[i] == fillSid &&
                             entLevel[i] == fillLevel && entFrame[i] == fillFrame;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
    end else if (strb.invEn) begin
      entValid <= entValid & ~killVec;
    end else if (strb.fillEn) begin
      entValid <= (strb.flushAll ? '0 : entValid) | slotHot;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.fillEn) begin
      entSid[fillSlot]   <= fillSid;
      entDid[fillSlot]   <= fillDid;
      entFrame[fillSlot] <= fillFrame;
      entLeaf[fillSlot]  <= fillLeaf;
      entLevel[fillSlot] <= fillLevel;
      entRd[fillSlot]    <= fillRead;
      entWr[fillSlot]    <= fillWrite;
    end
  end

  logic [ADDR_W-1:0] selMask;
  assign selMask = lvlMask(entLevel[selIdx]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid      <= 1'b0;
      rspHit        <= 1'b0;
      rspAddr       <= '0;
      rspOffsetMask <= '0;
      rspPerm       <= '0;
      rspLevel      <= '0;
    end else begin
      rspValid <= lookupValid;
      if (lookupValid && found) begin
        rspHit        <= 1'b1;
        rspAddr       <= entLeaf[selIdx] & selMask;
        rspOffsetMask <= ~selMask;
        rspPerm       <= {entWr[selIdx], entRd[selIdx]};
        rspLevel      <= entLevel[selIdx];
      end else begin
        rspHit        <= 1'b0;
        rspAddr       <= '0;
        rspOffsetMask <= '0;
        rspPerm       <= '0;
        rspLevel      <= '0;
      end
    end
  end

  // R6: in-place replacement keeps every tag unique
  p_unique_tag_r6: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |-> ($onehot0(hitVec[1]) && $onehot0(hitVec[2]) && $onehot0(hitVec[3])));

  // R7: an overflowing fill leaves only the new entry behind
  p_flush_one_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fillEn && strb.flushAll) |=> ($countones(entValid) == 1));

  // R8: a global invalidation empties the array
  p_global_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.invEn && strb.invKind == INV_GLOBAL) |=> (entValid == '0));

  // R2: a miss or an idle cycle drives zero data
  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rspHit |-> (rspAddr == '0 && rspOffsetMask == '0 && rspPerm == 2'd0 && rspLevel == 2'd0));

endmodule

// File: rtl/io_xlate_cache.sv
module io_xlate_cache
  import ioxc_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 48,
  parameter int SID_W       = 16,
  parameter int DID_W       = 16,
  parameter int ORDER_W     = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic [SID_W-1:0]   lookupSid,
  input  logic [ADDR_W-1:0]  lookupAddr,
  input  logic               fillValid,
  input  logic [SID_W-1:0]   fillSid,
  input  logic [DID_W-1:0]   fillDid,
  input  logic [ADDR_W-1:0]  fillAddr,
  input  logic [ADDR_W-1:0]  fillLeaf,
  input  logic               fillRead,
  input  logic               fillWrite,
  input  logic [1:0]         fillLevel,
  input  logic               invValid,
  input  logic [1:0]         invKind,
  input  logic [DID_W-1:0]   invDid,
  input  logic [ADDR_W-1:0]  invAddr,
  input  logic [ORDER_W-1:0] invOrder,
  output logic               rspValid,
  output logic               rspHit,
  output logic [ADDR_W-1:0]  rspAddr,
  output logic [ADDR_W-1:0]  rspOffsetMask,
  output logic [1:0]         rspPerm,
  output logic [1:0]         rspLevel,
  output logic               invDone
);

  localparam int SLOT_W = $clog2(NUM_ENTRIES);

  ctrlStrb_t              strb;
  logic [SLOT_W-1:0]      fillSlot;
  logic [NUM_ENTRIES-1:0] validVec;
  logic [NUM_ENTRIES-1:0] fillMatchVec;

  ioxc_ctrl #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .SLOT_W     (SLOT_W)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .fillValid   (fillValid),
    .fillLevel   (fillLevel),
    .invValid    (invValid),
    .invKind     (invKind),
    .validVec    (validVec),
    .fillMatchVec(fillMatchVec),
    .strb        (strb),
    .fillSlot    (fillSlot),
    .invDone     (invDone)
  );

  ioxc_store #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .ADDR_W     (ADDR_W),
    .SID_W      (SID_W),
    .DID_W      (DID_W),
    .ORDER_W    (ORDER_W),
    .SLOT_W     (SLOT_W)
  ) store_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .fillSlot     (fillSlot),
    .fillSid      (fillSid),
    .fillDid      (fillDid),
    .fillAddr     (fillAddr),
    .fillLeaf     (fillLeaf),
    .fillRead     (fillRead),
    .fillWrite    (fillWrite),
    .fillLevel    (fillLevel),
    .invDid       (invDid),
    .invAddr      (invAddr),
    .invOrder     (invOrder),
    .lookupValid  (lookupValid),
    .lookupSid    (lookupSid),
    .lookupAddr   (lookupAddr),
    .validVec     (validVec),
    .fillMatchVec (fillMatchVec),
    .rspValid     (rspValid),
    .rspHit       (rspHit),
    .rspAddr      (rspAddr),
    .rspOffsetMask(rspOffsetMask),
    .rspPerm      (rspPerm),
    .rspLevel     (rspLevel)
  );

  // R8: every invalidation request is acknowledged on the next cycle
  p_done_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    invValid |=> invDone);

  // R2: a result is presented only for a request made one cycle earlier
  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(lookupValid));

endmodule

// File: tb/io_xlate_cache_tb_top.sv
module io_xlate_cache_tb_top;

  localparam int  CLK_PERIOD = 10;
  localparam int  N          = 16;
  localparam longint AMASK   = (64'd1 << 48) - 1;
  localparam longint FMASK   = (64'd1 << 36) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 0;
  logic [15:0] lookupSid = '0;
  logic [47:0] lookupAddr = '0;
  logic        fillValid = 0;
  logic [15:0] fillSid = '0;
  logic [15:0] fillDid = '0;
  logic [47:0] fillAddr = '0;
  logic [47:0] fillLeaf = '0;
  logic        fillRead = 0;
  logic        fillWrite = 0;
  logic [1:0]  fillLevel = '0;
  logic        invValid = 0;
  logic [1:0]  invKind = '0;
  logic [15:0] invDid = '0;
  logic [47:0] invAddr = '0;
  logic [5:0]  invOrder = '0;
  logic        rspValid, rspHit, invDone;
  logic [47:0] rspAddr, rspOffsetMask;
  logic [1:0]  rspPerm, rspLevel;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_xlate_cache dut_i (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupSid(lookupSid), .lookupAddr(lookupAddr),
    .fillValid(fillValid), .fillSid(fillSid), .fillDid(fillDid), .fillAddr(fillAddr),
    .fillLeaf(fillLeaf), .fillRead(fillRead), .fillWrite(fillWrite), .fillLevel(fillLevel),
    .invValid(invValid), .invKind(invKind), .invDid(invDid), .invAddr(invAddr),
    .invOrder(invOrder),
    .rspValid(rspValid), .rspHit(rspHit), .rspAddr(rspAddr), .rspOffsetMask(rspOffsetMask),
    .rspPerm(rspPerm), .rspLevel(rspLevel), .invDone(invDone)
  );

  int    tests = 0;
  int    fails = 0;
  string curReq = "R1";

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct {
    longint sid; longint did; longint lvl; longint frame; longint leaf; bit rd; bit wr;
  } ment_t;
  ment_t mq[$];

  logic        eV, eH, eD;
  logic [47:0] eA, eO;
  logic [1:0]  eP, eL;

  function automatic longint lmask(input longint l);
    return (~((64'd1 << (12 + (l - 1) * 9)) - 1)) & AMASK;
  endfunction

  function automatic longint frameOf(input longint a, input longint l);
    return (a & lmask(l)) >> 12;
  endfunction

  function automatic bit killIt(input ment_t e);
    longint om, g, gt;
    case (invKind)
      2'd0: return 1'b1;
      2'd1: return e.did == longint'(invDid);
      2'd2: begin
        om = (~((64'd1 << invOrder) - 1)) & FMASK;
        g  = (longint'(invAddr) >> 12) & om;
        gt = (longint'(invAddr) & lmask(e.lvl)) >> 12;
        return e.did == longint'(invDid) && (((e.frame & om) == g) || (e.frame == gt));
      end
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mq.delete();
      eV = 0; eH = 0; eD = 0; eA = '0; eO = '0; eP = '0; eL = '0;
    end else begin
      eV = lookupValid; eH = 0; eA = '0; eO = '0; eP = '0; eL = '0;
      if (lookupValid) begin
        for (int l = 1; l <= 3; l++) begin
          for (int k = 0; k < mq.size(); k++) begin
            if (!eH && mq[k].sid == longint'(lookupSid) && mq[k].lvl == l &&
                mq[k].frame == frameOf(longint'(lookupAddr), l)) begin
              eH = 1;
              eA = 48'(mq[k].leaf & lmask(l));
              eO = 48'(~lmask(l) & AMASK);
              eP = {mq[k].wr, mq[k].rd};
              eL = 2'(l);
            end
          end
        end
      end
      eD = invValid;
      if (invValid) begin
        for (int k = mq.size() - 1; k >= 0; k--) if (killIt(mq[k])) mq.delete(k);
      end else if (fillValid && fillLevel != 2'd0) begin
        ment_t ne;
        int    at;
        ne.sid = longint'(fillSid); ne.did = longint'(fillDid); ne.lvl = longint'(fillLevel);
        ne.frame = frameOf(longint'(fillAddr), longint'(fillLevel));
        ne.leaf = longint'(fillLeaf); ne.rd = fillRead; ne.wr = fillWrite;
        at = -1;
        for (int k = 0; k < mq.size(); k++)
          if (mq[k].sid == ne.sid && mq[k].lvl == ne.lvl && mq[k].frame == ne.frame) at = k;
        if (at >= 0) mq[at] = ne;
        else begin
          if (mq.size() == N) mq.delete();
          mq.push_back(ne);
        end
      end
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    chk(curReq, "rspValid", 64'(rspValid), 64'(eV));
    chk(curReq, "rspHit", 64'(rspHit), 64'(eH));
    chk(curReq, "rspAddr", 64'(rspAddr), 64'(eA));
    chk(curReq, "rspOffsetMask", 64'(rspOffsetMask), 64'(eO));
    chk(curReq, "rspPerm", 64'(rspPerm), 64'(eP));
    chk(curReq, "rspLevel", 64'(rspLevel), 64'(eL));
    chk(curReq, "invDone", 64'(invDone), 64'(eD));
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doFill(input logic [15:0] s, input logic [15:0] d, input logic [47:0] a,
                        input logic [47:0] lf, input logic r, input logic w,
                        input logic [1:0] lv);
    fillValid = 1; fillSid = s; fillDid = d; fillAddr = a; fillLeaf = lf;
    fillRead = r; fillWrite = w; fillLevel = lv;
    tick();
    fillValid = 0;
  endtask

  task automatic doLook(input logic [15:0] s, input logic [47:0] a);
    lookupValid = 1; lookupSid = s; lookupAddr = a;
    tick();
    lookupValid = 0;
  endtask

  task automatic doInv(input logic [1:0] k, input logic [15:0] d, input logic [47:0] a,
                       input logic [5:0] o);
    invValid = 1; invKind = k; invDid = d; invAddr = a; invOrder = o;
    tick();
    invValid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: empty after reset
    curReq = "R1";
    chk("R1", "reset rspValid", 64'(rspValid), 0);
    chk("R1", "reset invDone", 64'(invDone), 0);
    doLook(16'h1, 48'h1000);
    chk("R1", "empty lookup valid", 64'(rspValid), 1);
    chk("R1", "empty lookup miss", 64'(rspHit), 0);

    // R3: tag = source, level, frame
    curReq = "R3";
    doFill(16'h1, 16'h1, 48'h1000, 48'hAAAAB000, 1, 1, 2'd1);
    doLook(16'h1, 48'h1FFF);
    chk("R3", "4K hit", 64'(rspHit), 1);
    chk("R3", "4K addr", 64'(rspAddr), 64'hAAAAB000);
    doLook(16'h2, 48'h1FFF);
    chk("R3", "other sid miss", 64'(rspHit), 0);
    doLook(16'h1, 48'h2000);
    chk("R3", "next page miss", 64'(rspHit), 0);

    // R5: large page output formation
    curReq = "R5";
    doFill(16'h12, 16'h2, 48'h40600000, 48'h123456789000, 1, 0, 2'd2);
    doLook(16'h12, 48'h40712345);
    chk("R5", "2M addr", 64'(rspAddr), 64'h123456600000);
    chk("R5", "2M offset mask", 64'(rspOffsetMask), 64'h1FFFFF);
    chk("R5", "2M perm read only", 64'(rspPerm), 1);
    chk("R5", "2M level", 64'(rspLevel), 2);
    doFill(16'h13, 16'h2, 48'h80000000, 48'hFC1234000, 0, 1, 2'd3);
    doLook(16'h13, 48'hBFFFFFFF);
    chk("R5", "1G addr", 64'(rspAddr), 64'hFC0000000);
    chk("R5", "1G offset mask", 64'(rspOffsetMask), 64'h3FFFFFFF);
    chk("R5", "1G perm write only", 64'(rspPerm), 2);

    // R4: level priority
    curReq = "R4";
    doFill(16'h7, 16'h1, 48'h0, 48'h300000000, 1, 1, 2'd3);
    doFill(16'h7, 16'h1, 48'h5000, 48'h9000, 1, 1, 2'd1);
    doLook(16'h7, 48'h5004);
    chk("R4", "level 1 wins", 64'(rspLevel), 1);
    chk("R4", "level 1 addr", 64'(rspAddr), 64'h9000);
    doLook(16'h7, 48'h6000);
    chk("R4", "falls to level 3", 64'(rspLevel), 3);

    // R6: in-place replacement
    curReq = "R6";
    doFill(16'h1, 16'h1, 48'h1000, 48'hBBBBC000, 1, 0, 2'd1);
    doLook(16'h1, 48'h1000);
    chk("R6", "replaced leaf", 64'(rspAddr), 64'hBBBBC000);
    chk("R6", "replaced perm", 64'(rspPerm), 1);

    // R8 then R7: fill to capacity, replace in place, overflow
    curReq = "R8";
    doInv(2'd0, 16'h0, 48'h0, 6'd0);
    chk("R8", "done pulse", 64'(invDone), 1);
    doLook(16'h1, 48'h1000);
    chk("R8", "global cleared", 64'(rspHit), 0);
    chk("R8", "done single cycle", 64'(invDone), 0);
    curReq = "R7";
    for (int i = 0; i < N; i++)
      doFill(16'h5, 16'h1, 48'(i) << 12, 48'(i + 256) << 12, 1, 1, 2'd1);
    doFill(16'h5, 16'h1, 48'h3000, 48'h777000, 1, 1, 2'd1);
    doLook(16'h5, 48'h0);
    chk("R6", "full but same tag keeps others", 64'(rspHit), 1);
    doLook(16'h5, 48'h3000);
    chk("R6", "full same tag updated", 64'(rspAddr), 64'h777000);
    doFill(16'h5, 16'h1, 48'h100000, 48'hABC000, 1, 1, 2'd1);
    doLook(16'h5, 48'h0);
    chk("R7", "overflow flushed old", 64'(rspHit), 0);
    doLook(16'h5, 48'h100000);
    chk("R7", "overflow kept new", 64'(rspAddr), 64'hABC000);

    // R9: domain invalidation
    curReq = "R9";
    doInv(2'd0, 16'h0, 48'h0, 6'd0);
    doFill(16'h8, 16'h1, 48'h1000, 48'h11000, 1, 1, 2'd1);
    doFill(16'h8, 16'h2, 48'h2000, 48'h22000, 1, 1, 2'd1);
    doInv(2'd1, 16'h1, 48'h0, 6'd0);
    doLook(16'h8, 48'h1000);
    chk("R9", "domain 1 removed", 64'(rspHit), 0);
    doLook(16'h8, 48'h2000);
    chk("R9", "domain 2 kept", 64'(rspHit), 1);

    // R10: page invalidation, both match forms
    curReq = "R10";
    doInv(2'd0, 16'h0, 48'h0, 6'd0);
    for (int i = 0; i < 8; i++)
      doFill(16'h9, 16'h3, 48'(i + 256) << 12, 48'(i + 512) << 12, 1, 1, 2'd1);
    doInv(2'd2, 16'h3, 48'h104000, 6'd2);
    for (int i = 0; i < 8; i++) begin
      doLook(16'h9, 48'(i + 256) << 12);
      chk("R10", "range flush", 64'(rspHit), (i < 4) ? 64'd1 : 64'd0);
    end
    doFill(16'h9, 16'h3, 48'h40000000, 48'h80000000, 1, 1, 2'd2);
    doFill(16'hA, 16'h4, 48'h40000000, 48'h80000000, 1, 1, 2'd2);
    doInv(2'd2, 16'h3, 48'h40010000, 6'd0);
    doLook(16'h9, 48'h40000000);
    chk("R10", "large entry containing addr removed", 64'(rspHit), 0);
    doLook(16'hA, 48'h40000000);
    chk("R10", "other domain large entry kept", 64'(rspHit), 1);

    // R11: dropped and no-op requests
    curReq = "R11";
    fillValid = 1; fillSid = 16'hB; fillDid = 16'h1; fillAddr = 48'h1000; fillLeaf = 48'h5000;
    fillRead = 1; fillWrite = 1; fillLevel = 2'd1;
    invValid = 1; invKind = 2'd3;
    tick();
    fillValid = 0; invValid = 0;
    chk("R11", "no-op kind done", 64'(invDone), 1);
    doLook(16'hB, 48'h1000);
    chk("R11", "fill with inv dropped", 64'(rspHit), 0);
    doFill(16'hB, 16'h1, 48'h1000, 48'h5000, 1, 1, 2'd0);
    doLook(16'hB, 48'h1000);
    chk("R11", "level 0 fill dropped", 64'(rspHit), 0);
    doFill(16'hB, 16'h1, 48'h1000, 48'h5000, 1, 1, 2'd1);
    doInv(2'd3, 16'h1, 48'h1000, 6'd0);
    doLook(16'hB, 48'h1000);
    chk("R11", "no-op kind keeps entry", 64'(rspHit), 1);

    // R2: lookup sees pre-fill contents
    curReq = "R2";
    lookupValid = 1; lookupSid = 16'hC; lookupAddr = 48'h7000;
    fillValid = 1; fillSid = 16'hC; fillDid = 16'h1; fillAddr = 48'h7000; fillLeaf = 48'hE000;
    fillRead = 1; fillWrite = 0; fillLevel = 2'd1;
    tick();
    lookupValid = 0; fillValid = 0;
    chk("R2", "same-cycle fill not seen", 64'(rspHit), 0);
    chk("R2", "miss data zero", 64'(rspAddr), 0);
    doLook(16'hC, 48'h7000);
    chk("R2", "next lookup hit", 64'(rspHit), 1);
    tick();
    chk("R2", "valid one cycle", 64'(rspValid), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule